// File: doc/BRIEF.md
# Root Power-Level Arbiter

This block sits at the top of a binary tree of power controllers. Its two child ports each carry a request for one of five power levels. The block keeps a record of the level that each child currently holds, and it settles every request locally because it has no parent. It grants any change unless that change would leave both children at the highest level at once. It answers with a one-cycle grant or deny pulse. It then ignores all further requests until the served child acknowledges. On that acknowledge, a granted level is committed to the record.

A per-child fence input adds a deny rule. A child is fenced when its fence input is high, it sits at the lowest level and its sibling sits at the highest level. While fenced, the child is refused the two top levels but may still move to the lower ones. When the fence input drops, the block returns to the plain rule. Levels are encoded 0 = L, 1 = ML, 2 = M, 3 = MH, 4 = H. Both tracked levels are visible on output ports.

Top module: `pwr_root`

## Requirements
- R1: While reset is high and on the first cycle after it, both tracked levels read 0 (L), all grant and deny outputs are low, and the block accepts a new request.
- R2: A request from either child for any level 0..4 is answered with a grant unless a deny rule applies. The tracked level of that child takes the requested value on the clock edge where the child's ack is sampled, and at no other time.
- R3: A request for level 4 (H) while the sibling's tracked level is 4 is answered with a deny. The requester's tracked level is unchanged after its ack.
- R4: From the cycle a response is issued until the served child's ack is sampled, requests from both children are ignored and produce no response. An ack from the child that was not served has no effect.
- R5: The response is a single-cycle pulse, visible in the cycle after the request is sampled. At most one of the four response outputs is high in any cycle.
- R6: When both children request in the same idle cycle, the left child is served and the right request is dropped.
- R7: A request for the level a child already holds is granted and leaves both tracked levels unchanged.
- R8: A child is fenced one cycle after these conditions hold together: its fence input is high, its level is 0 and its sibling's level is 4. A fenced child's requests for level 3 or 4 are denied, and its requests for levels 1 or 2 are granted.
- R9: One cycle after the fence input drops, the fence is released and the child's requests follow R2 and R3 again.
- R10: The two tracked levels are never both 4 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_req_vld | input | 1 | Left child request strobe |
| l_req_lvl | input | 3 | Level requested by left child |
| l_ack | input | 1 | Left child acknowledge of a response |
| l_fence | input | 1 | Cap left child below level 3 while the right child is at 4 |
| l_gnt | output | 1 | Grant pulse to left child |
| l_dny | output | 1 | Deny pulse to left child |
| l_lvl | output | 3 | Tracked level of left child |
| r_req_vld | input | 1 | Right child request strobe |
| r_req_lvl | input | 3 | Level requested by right child |
| r_ack | input | 1 | Right child acknowledge of a response |
| r_fence | input | 1 | Cap right child below level 3 while the left child is at 4 |
| r_gnt | output | 1 | Grant pulse to right child |
| r_dny | output | 1 | Deny pulse to right child |
| r_lvl | output | 3 | Tracked level of right child |

## Verification
The properties assume that requested levels never exceed 4. They also assume that a child raises its ack only after it has received a response, and holds the ack for a single cycle. The bench keeps to these assumptions: it issues each request as a one-cycle strobe, and it acks once per response in the cycle after the pulse. The only stray acks and requests it sends are the ones issued on purpose while the block is blocked, and there the rules say those inputs must have no effect.

// File: rtl/pwr_root_pkg.sv
package pwr_root_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_t;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/pwr_root_rule.sv
module pwr_root_rule #(
  parameter int LVL_W  = 3,
  parameter int HI_LVL = 4,
  parameter int CAP_LVL = 3
) (
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [LVL_W-1:0] sib_lvl,
  input  logic             fenced,
  output logic             allow
);
  logic double_hi;
  logic capped;

  always_comb begin
    double_hi = (req_lvl == LVL_W'(HI_LVL)) && (sib_lvl == LVL_W'(HI_LVL));
    capped    = fenced && (req_lvl >= LVL_W'(CAP_LVL));
    allow     = !double_hi && !capped;
  end
endmodule

// File: rtl/pwr_root_fence.sv
module pwr_root_fence #(
  parameter int LVL_W  = 3,
  parameter int HI_LVL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             fence_in,
  input  logic [LVL_W-1:0] own_lvl,
  input  logic [LVL_W-1:0] sib_lvl,
  output logic             fenced
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fenced <= 1'b0;
    end else if (!hold) begin
      fenced <= fence_in && (own_lvl == '0) && (sib_lvl == LVL_W'(HI_LVL));
    end
  end
endmodule

// File: rtl/pwr_root.sv
module pwr_root #(
  parameter int HI_LVL  = 4,
  parameter int CAP_LVL = HI_LVL - 1,
  parameter int LVL_W   = $clog2(HI_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_req_vld,
  input  logic [LVL_W-1:0] l_req_lvl,
  input  logic             l_ack,
  input  logic             l_fence,
  output logic             l_gnt,
  output logic             l_dny,
  output logic [LVL_W-1:0] l_lvl,
  input  logic             r_req_vld,
  input  logic [LVL_W-1:0] r_req_lvl,
  input  logic             r_ack,
  input  logic             r_fence,
  output logic             r_gnt,
  output logic             r_dny,
  output logic [LVL_W-1:0] r_lvl
);
  import pwr_root_pkg::*;

  logic             req_v  [NUM_SIDES];
  logic [LVL_W-1:0] req_l  [NUM_SIDES];
  logic             ack_v  [NUM_SIDES];
  logic             fen_in [NUM_SIDES];
  logic [LVL_W-1:0] lvl_q  [NUM_SIDES];
  logic             gnt_q  [NUM_SIDES];
  logic             dny_q  [NUM_SIDES];
  logic             fenced [NUM_SIDES];
  logic             allow  [NUM_SIDES];

  logic             busy_q;
  side_t            side_q;
  logic             ok_q;
  logic [LVL_W-1:0] tgt_q;
  side_t            pick;
  logic             any_req;

  assign req_v[0]  = l_req_vld;
  assign req_v[1]  = r_req_vld;
  assign req_l[0]  = l_req_lvl;
  assign req_l[1]  = r_req_lvl;
  assign ack_v[0]  = l_ack;
  assign ack_v[1]  = r_ack;
  assign fen_in[0] = l_fence;
  assign fen_in[1] = r_fence;

  genvar s;
  generate
    for (s = 0; s < NUM_SIDES; s++) begin : g_side
      pwr_root_fence #(.LVL_W(LVL_W), .HI_LVL(HI_LVL)) u_fence (
        .clk      (clk),
        .rst      (rst),
        .hold     (busy_q),
        .fence_in (fen_in[s]),
        .own_lvl  (lvl_q[s]),
        .sib_lvl  (lvl_q[NUM_SIDES-1-s]),
        .fenced   (fenced[s])
      );
      pwr_root_rule #(.LVL_W(LVL_W), .HI_LVL(HI_LVL), .CAP_LVL(CAP_LVL)) u_rule (
        .req_lvl (req_l[s]),
        .sib_lvl (lvl_q[NUM_SIDES-1-s]),
        .fenced  (fenced[s]),
        .allow   (allow[s])
      );
    end
  endgenerate

  always_comb begin
    any_req = req_v[0] || req_v[1];
    pick    = req_v[0] ? SIDE_L : SIDE_R;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      side_q <= SIDE_L;
      ok_q   <= 1'b0;
      tgt_q  <= '0;
      for (int i = 0; i < NUM_SIDES; i++) begin
        lvl_q[i] <= '0;
        gnt_q[i] <= 1'b0;
        dny_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NUM_SIDES; i++) begin
        gnt_q[i] <= 1'b0;
        dny_q[i] <= 1'b0;
      end
      if (!busy_q) begin
        if (any_req) begin
          busy_q <= 1'b1;
          side_q <= pick;
          ok_q   <= allow[pick];
          tgt_q  <= req_l[pick];
          if (allow[pick]) gnt_q[pick] <= 1'b1;
          else             dny_q[pick] <= 1'b1;
        end
      end else if (ack_v[side_q]) begin
        busy_q <= 1'b0;
        if (ok_q) lvl_q[side_q] <= tgt_q;
      end
    end
  end

  assign l_gnt = gnt_q[0];
  assign l_dny = dny_q[0];
  assign l_lvl = lvl_q[0];
  assign r_gnt = gnt_q[1];
  assign r_dny = dny_q[1];
  assign r_lvl = lvl_q[1];
endmodule

// File: rtl/pwr_root_chk.sv
module pwr_root_chk #(
  parameter int HI_LVL = 4,
  parameter int LVL_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             l_req_vld,
  input logic [LVL_W-1:0] l_req_lvl,
  input logic             l_ack,
  input logic             l_gnt,
  input logic             l_dny,
  input logic [LVL_W-1:0] l_lvl,
  input logic             r_req_vld,
  input logic [LVL_W-1:0] r_req_lvl,
  input logic             r_ack,
  input logic             r_gnt,
  input logic             r_dny,
  input logic [LVL_W-1:0] r_lvl
);
  logic any_resp;
  assign any_resp = l_gnt || l_dny || r_gnt || r_dny;

  AST_NEVER_BOTH_HIGH: assert property (@(posedge clk) disable iff (rst)
    !((l_lvl == LVL_W'(HI_LVL)) && (r_lvl == LVL_W'(HI_LVL)))); // R10

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l_gnt, l_dny, r_gnt, r_dny})); // R5

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    any_resp |=> !any_resp); // R4

  AST_LEFT_LVL_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (l_lvl != $past(l_lvl)) |-> $past(l_ack)); // R2

  AST_RIGHT_LVL_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (r_lvl != $past(r_lvl)) |-> $past(r_ack)); // R2

  AST_DENY_DOUBLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!busy && l_req_vld && (l_req_lvl == LVL_W'(HI_LVL)) && (r_lvl == LVL_W'(HI_LVL)))
    |=> l_dny); // R3

  AST_LEFT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!busy && l_req_vld && r_req_vld) |=> (!r_gnt && !r_dny)); // R6
endmodule

bind pwr_root pwr_root_chk #(.HI_LVL(HI_LVL), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy_q),
  .l_req_vld (l_req_vld),
  .l_req_lvl (l_req_lvl),
  .l_ack     (l_ack),
  .l_gnt     (l_gnt),
  .l_dny     (l_dny),
  .l_lvl     (l_lvl),
  .r_req_vld (r_req_vld),
  .r_req_lvl (r_req_lvl),
  .r_ack     (r_ack),
  .r_gnt     (r_gnt),
  .r_dny     (r_dny),
  .r_lvl     (r_lvl)
);

// File: tb/pwr_root_tb.sv
module pwr_root_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rst;
  logic l_req_vld, l_ack, l_fence, l_gnt, l_dny;
  logic r_req_vld, r_ack, r_fence, r_gnt, r_dny;
  logic [2:0] l_req_lvl, r_req_lvl, l_lvl, r_lvl;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_root u_dut (
    .clk(clk), .rst(rst),
    .l_req_vld(l_req_vld), .l_req_lvl(l_req_lvl), .l_ack(l_ack), .l_fence(l_fence),
    .l_gnt(l_gnt), .l_dny(l_dny), .l_lvl(l_lvl),
    .r_req_vld(r_req_vld), .r_req_lvl(r_req_lvl), .r_ack(r_ack), .r_fence(r_fence),
    .r_gnt(r_gnt), .r_dny(r_dny), .r_lvl(r_lvl)
  );

  // {side(1=right), req level, expect grant, expected left, expected right}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 3'd4, 1'b1, 3'd4, 3'd0},
    {1'b1, 3'd4, 1'b0, 3'd4, 3'd0},
    {1'b1, 3'd3, 1'b1, 3'd4, 3'd3},
    {1'b0, 3'd4, 1'b1, 3'd4, 3'd3},
    {1'b1, 3'd4, 1'b0, 3'd4, 3'd3},
    {1'b0, 3'd2, 1'b1, 3'd2, 3'd3},
    {1'b1, 3'd4, 1'b1, 3'd2, 3'd4},
    {1'b0, 3'd4, 1'b0, 3'd2, 3'd4},
    {1'b0, 3'd0, 1'b1, 3'd0, 3'd4},
    {1'b1, 3'd1, 1'b1, 3'd0, 3'd1},
    {1'b0, 3'd1, 1'b1, 3'd1, 3'd1},
    {1'b1, 3'd0, 1'b1, 3'd1, 3'd0},
    {1'b0, 3'd0, 1'b1, 3'd0, 3'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // request, check pulse, ack, check levels
  task automatic serve(input string req, input bit side, input logic [2:0] lvl,
                       input bit exp_gnt, input int exp_l, input int exp_r);
    if (side) begin r_req_vld = 1'b1; r_req_lvl = lvl; end
    else      begin l_req_vld = 1'b1; l_req_lvl = lvl; end
    @(negedge clk);
    l_req_vld = 1'b0; r_req_vld = 1'b0;
    check({req, " grant"}, side ? r_gnt : l_gnt, exp_gnt);
    check({req, " deny"},  side ? r_dny : l_dny, !exp_gnt);
    if (side) r_ack = 1'b1; else l_ack = 1'b1;
    @(negedge clk);
    l_ack = 1'b0; r_ack = 1'b0;
    check({req, " pulse ends"}, l_gnt | l_dny | r_gnt | r_dny, 0);
    check({req, " left level"}, l_lvl, exp_l);
    check({req, " right level"}, r_lvl, exp_r);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    l_req_vld = 0; l_req_lvl = 0; l_ack = 0; l_fence = 0;
    r_req_vld = 0; r_req_lvl = 0; r_ack = 0; r_fence = 0;
    idle_cycles(3);
    // R1 reset state
    check("R1 left level", l_lvl, 0);
    check("R1 right level", r_lvl, 0);
    check("R1 responses", l_gnt | l_dny | r_gnt | r_dny, 0);
    rst = 1'b0;

    // R2 R3 R7 vector walk
    for (int v = 0; v < NVEC; v++) begin
      serve("R2/R3/R7 vector", VEC[v][10], VEC[v][9:7], VEC[v][6], VEC[v][5:3], VEC[v][2:0]);
    end

    // R4 stall: left served, right requests and acks ignored
    l_req_vld = 1'b1; l_req_lvl = 3'd2;
    @(negedge clk);
    l_req_vld = 1'b0;
    check("R4 first grant", l_gnt, 1);
    r_req_vld = 1'b1; r_req_lvl = 3'd3;
    idle_cycles(2);
    check("R4 right stalled", r_gnt | r_dny, 0);
    r_req_vld = 1'b0; r_ack = 1'b1;
    @(negedge clk);
    r_ack = 1'b0;
    check("R4 foreign ack ignored", l_lvl, 0);
    check("R4 right unchanged", r_lvl, 0);
    l_ack = 1'b1;
    @(negedge clk);
    l_ack = 1'b0;
    check("R4 left committed", l_lvl, 2);
    check("R4 no late right resp", r_gnt | r_dny, 0);

    // R6 simultaneous requests: left wins
    l_req_vld = 1'b1; l_req_lvl = 3'd1;
    r_req_vld = 1'b1; r_req_lvl = 3'd4;
    @(negedge clk);
    l_req_vld = 1'b0; r_req_vld = 1'b0;
    check("R6 left served", l_gnt, 1);
    check("R6 right dropped", r_gnt | r_dny, 0);
    l_ack = 1'b1;
    @(negedge clk);
    l_ack = 1'b0;
    idle_cycles(1);
    check("R6 left level", l_lvl, 1);
    check("R6 right level", r_lvl, 0);

    // R8 fence on left with right at H
    serve("R8 setup", 1'b0, 3'd0, 1'b1, 0, 0);
    serve("R8 setup", 1'b1, 3'd4, 1'b1, 0, 4);
    l_fence = 1'b1;
    idle_cycles(2);
    serve("R8 fenced MH", 1'b0, 3'd3, 1'b0, 0, 4);
    serve("R8 fenced H",  1'b0, 3'd4, 1'b0, 0, 4);
    serve("R8 fenced M",  1'b0, 3'd2, 1'b1, 2, 4);
    serve("R8 back to L", 1'b0, 3'd0, 1'b1, 0, 4);
    idle_cycles(1);
    // R9 release
    l_fence = 1'b0;
    idle_cycles(2);
    serve("R9 released MH", 1'b0, 3'd3, 1'b1, 3, 4);
    // R8 symmetric on right
    serve("R8 setup", 1'b1, 3'd0, 1'b1, 3, 0);
    serve("R8 setup", 1'b0, 3'd4, 1'b1, 4, 0);
    r_fence = 1'b1;
    idle_cycles(2);
    serve("R8 right fenced MH", 1'b1, 3'd3, 1'b0, 4, 0);
    serve("R8 right fenced ML", 1'b1, 3'd1, 1'b1, 4, 1);
    r_fence = 1'b0;

    // R1 reset mid-operation
    rst = 1'b1;
    idle_cycles(2);
    rst = 1'b0;
    check("R1 re-reset left", l_lvl, 0);
    check("R1 re-reset right", r_lvl, 0);
    serve("R1 accepts after reset", 1'b1, 3'd4, 1'b1, 0, 4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule